// File: doc/BRIEF.md
# Character Glyph Font Memory Programmer

This block writes one character glyph into the non-volatile font store of an external on-screen-display device. A caller loads the 54 bytes of the glyph into a small local buffer, presents a character index and pulses `start`. The block then drives a fixed series of register transactions through a single-request SPI transaction port. The series first switches the overlay off. It then sets the character address and stages each glyph byte in the device's shadow RAM. After that it issues the commit command and keeps reading the status register until the device reports that the commit has finished.

Other masters share the SPI link with this block. A start is therefore accepted only while no other user holds the bus lock. The block holds its own lock and keeps chip-select asserted from the first transaction until completion. A commit can hang. A poll budget set by the caller bounds how long the block waits, and running out of budget ends the operation with an error flag.

Top module: `font_nvm_prog`

## Requirements
- R1: After reset the block is idle: `cs_n`=1, `lock_own`=0, `txn_req`=0, `done`=0, `err`=0.
- R2: A `start` pulse is ignored while `bus_lock_busy`=1, and also while an operation is running. An ignored pulse causes no transaction, no lock and no change to the sequence in progress.
- R3: An accepted operation first writes 0x00 to register 0x00, which turns the display off. It next writes the character index, captured when `start` was accepted, to register 0x09.
- R4: For each byte index i, from 0 to 53 in ascending order, the block writes i to register 0x0A and then writes the glyph byte to register 0x0B. The glyph byte is the value returned on `gb_data` while `gb_addr`=i.
- R5: After the last byte the block writes 0xA0 to register 0x08, the commit, and its next transaction is a read (`txn_write`=0) of register 0xA0.
- R6: The block repeats the status read while bit 5 of `txn_rdata` is 1 and ignores all other bits. The first read with bit 5 = 0 ends the operation with `err`=0.
- R7: `lock_own`=1 and `cs_n`=0 hold without a break from the cycle after the accepted `start` until the operation ends. In the `done` cycle both are released.
- R8: If `poll_limit` (at least 1) status reads all return bit 5 = 1, the operation ends with `err`=1 and issues no further transaction.
- R9: `done` is a one-cycle pulse. `err` keeps its value until the next accepted `start`, which clears it.
- R10: While `txn_req`=1 and `txn_ack`=0, the outputs `txn_write`, `txn_addr` and `txn_wdata` stay unchanged. A request advances only when `txn_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to program one glyph |
| char_idx | input | 8 | Character index to program |
| poll_limit | input | POLL_W | Most status reads allowed before error |
| bus_lock_busy | input | 1 | Another SPI user holds the bus lock |
| lock_own | output | 1 | This block holds the bus lock |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation timed out while polling |
| gb_addr | output | GB_AW | Glyph buffer byte index |
| gb_data | input | 8 | Glyph byte at `gb_addr` (combinational read) |
| cs_n | output | 1 | Device chip-select, active low |
| txn_req | output | 1 | Register transaction requested |
| txn_write | output | 1 | 1 = write, 0 = read |
| txn_addr | output | 8 | Device register address |
| txn_wdata | output | 8 | Write data |
| txn_ack | input | 1 | Transaction complete, one cycle |
| txn_rdata | input | 8 | Read data, valid with `txn_ack` |

## Verification
The assertions assume that the transaction port raises `txn_ack` only while `txn_req` is high and only for one cycle at a time. They also assume that `gb_data` responds combinationally to `gb_addr`. The bench responder keeps to these rules: it acknowledges each request after a fixed wait of two cycles and drops `txn_ack` after one cycle. It returns status bytes whose other bits are set to arbitrary values, so only bit 5 is meaningful. The bench holds `poll_limit` at 1 or more and keeps it constant for the whole of each operation.

// File: rtl/font_nvm_prog.sv
module font_nvm_prog #(
  parameter int NBYTES = 54,
  parameter int POLL_W = 16,
  parameter int GB_AW  = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        char_idx,
  input  logic [POLL_W-1:0] poll_limit,
  input  logic              bus_lock_busy,
  output logic              lock_own,
  output logic              done,
  output logic              err,
  output logic [GB_AW-1:0]  gb_addr,
  input  logic [7:0]        gb_data,
  output logic              cs_n,
  output logic              txn_req,
  output logic              txn_write,
  output logic [7:0]        txn_addr,
  output logic [7:0]        txn_wdata,
  input  logic              txn_ack,
  input  logic [7:0]        txn_rdata
);
  localparam logic [7:0] REG_MODE   = 8'h00;
  localparam logic [7:0] REG_CMD    = 8'h08;
  localparam logic [7:0] REG_HI     = 8'h09;
  localparam logic [7:0] REG_LO     = 8'h0A;
  localparam logic [7:0] REG_DATA   = 8'h0B;
  localparam logic [7:0] REG_STATUS = 8'hA0;
  localparam logic [7:0] CMD_COMMIT = 8'hA0;
  localparam int         BUSY_BIT   = 5;
  localparam logic [GB_AW-1:0] LAST = GB_AW'(NBYTES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_OFF, S_HI, S_LO, S_DAT, S_CMT, S_POLL, S_FIN
  } state_t;

  state_t            state;
  logic [7:0]        idx_q;
  logic [GB_AW-1:0]  bcnt;
  logic [POLL_W-1:0] pcnt;
  logic              err_q;
  logic              out_of_polls;

  assign out_of_polls = ({1'b0, pcnt} + 1'b1) >= {1'b0, poll_limit};

  assign lock_own  = (state != S_IDLE) && (state != S_FIN);
  assign cs_n      = !lock_own;
  assign txn_req   = lock_own;
  assign done      = (state == S_FIN);
  assign err       = err_q;
  assign gb_addr   = bcnt;
  assign txn_write = (state != S_POLL);

  always_comb begin
    txn_addr  = REG_MODE;
    txn_wdata = 8'h00;
    case (state)
      S_HI:   begin txn_addr = REG_HI;     txn_wdata = idx_q;              end
      S_LO:   begin txn_addr = REG_LO;     txn_wdata = 8'(bcnt);           end
      S_DAT:  begin txn_addr = REG_DATA;   txn_wdata = gb_data;            end
      S_CMT:  begin txn_addr = REG_CMD;    txn_wdata = CMD_COMMIT;         end
      S_POLL: begin txn_addr = REG_STATUS; txn_wdata = 8'h00;              end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx_q <= '0;
      bcnt  <= '0;
      pcnt  <= '0;
      err_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start && !bus_lock_busy) begin
          state <= S_OFF;
          idx_q <= char_idx;
          bcnt  <= '0;
          pcnt  <= '0;
          err_q <= 1'b0;
        end
        S_OFF: if (txn_ack) state <= S_HI;
        S_HI:  if (txn_ack) state <= S_LO;
        S_LO:  if (txn_ack) state <= S_DAT;
        S_DAT: if (txn_ack) begin
          if (bcnt == LAST) state <= S_CMT;
          else begin
            bcnt  <= bcnt + 1'b1;
            state <= S_LO;
          end
        end
        S_CMT: if (txn_ack) state <= S_POLL;
        S_POLL: if (txn_ack) begin
          if (!txn_rdata[BUSY_BIT]) state <= S_FIN;
          else if (out_of_polls) begin
            err_q <= 1'b1;
            state <= S_FIN;
          end else pcnt <= pcnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/font_nvm_prog_chk.sv
module font_nvm_prog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       bus_lock_busy,
  input logic       lock_own,
  input logic       done,
  input logic       err,
  input logic       cs_n,
  input logic       txn_req,
  input logic       txn_write,
  input logic [7:0] txn_addr,
  input logic [7:0] txn_wdata,
  input logic       txn_ack,
  input logic [7:0] txn_rdata
);
  a_r2_refuse_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_own && !done && start && bus_lock_busy) |=> !lock_own);

  a_r3_first_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_own) |-> (txn_req && txn_write && txn_addr == 8'h00 && txn_wdata == 8'h00));

  a_r5_commit_then_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_ack && txn_write && txn_addr == 8'h08) |=> (txn_req && !txn_write && txn_addr == 8'hA0));

  a_r6_clear_ends_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_ack && !txn_write && !txn_rdata[5]) |=> (done && !err));

  a_r7_lock_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(lock_own) && cs_n && !lock_own));

  a_r7_cs_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |-> !cs_n);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_own && !done) |=> (lock_own || $stable(err)));

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && !txn_ack) |=> (txn_req && $stable(txn_write) && $stable(txn_addr) && $stable(txn_wdata)));
endmodule

bind font_nvm_prog font_nvm_prog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_lock_busy(bus_lock_busy),
  .lock_own(lock_own), .done(done), .err(err), .cs_n(cs_n),
  .txn_req(txn_req), .txn_write(txn_write), .txn_addr(txn_addr),
  .txn_wdata(txn_wdata), .txn_ack(txn_ack), .txn_rdata(txn_rdata)
);

// File: tb/font_nvm_prog_bench.sv
module font_nvm_prog_bench;
  localparam int POLL_W = 16;
  localparam int GB_AW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] char_idx = '0;
  logic [POLL_W-1:0] poll_limit = 16'd8;
  logic bus_lock_busy = 1'b0;
  logic lock_own, done, err, cs_n, txn_req, txn_write;
  logic [GB_AW-1:0] gb_addr;
  logic [7:0] gb_data, txn_addr, txn_wdata;
  logic txn_ack = 1'b0;
  logic [7:0] txn_rdata = '0;

  logic [7:0] gbuf [64];
  logic [16:0] exp_q [$];
  int total = 0;
  int bad = 0;
  int busy_left = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign gb_data = gbuf[gb_addr];

  font_nvm_prog u_font_nvm_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .char_idx(char_idx),
    .poll_limit(poll_limit), .bus_lock_busy(bus_lock_busy),
    .lock_own(lock_own), .done(done), .err(err), .gb_addr(gb_addr),
    .gb_data(gb_data), .cs_n(cs_n), .txn_req(txn_req), .txn_write(txn_write),
    .txn_addr(txn_addr), .txn_wdata(txn_wdata), .txn_ack(txn_ack),
    .txn_rdata(txn_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Monitor and responder: pops expected transactions and acknowledges them.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txn_req) begin
        logic [16:0] got;
        got = {txn_write, txn_addr, txn_write ? txn_wdata : 8'h00};
        check(!cs_n && lock_own, "R7 cs/lock during txn", {cs_n, lock_own}, 1);
        if (exp_q.size() == 0) check(0, "R8 no transaction expected", int'(got), 0);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          check(got == e, (got[15:8] == 8'h0B) ? "R4 glyph byte" :
                (got[15:8] == 8'h0A) ? "R4 byte index" :
                (got[15:8] == 8'hA0) ? "R6 status read" :
                (got[15:8] == 8'h08) ? "R5 commit" : "R3 setup write",
                int'(got), int'(e));
        end
        @(negedge clk);
        check(txn_req && {txn_write, txn_addr, txn_write ? txn_wdata : 8'h00} == got,
              "R10 request held", int'({txn_write, txn_addr}), int'(got[16:8]));
        @(negedge clk);
        txn_rdata = (busy_left > 0) ? 8'h25 : 8'hDF;
        if (!txn_write) busy_left--;
        txn_ack = 1'b1;
        @(negedge clk);
        txn_ack = 1'b0;
        txn_rdata = 8'h00;
      end
    end
  end

  task automatic run(input logic [7:0] idx, input int busy, input int limit, input bit poke);
    int polls;
    bit expect_err;
    for (int i = 0; i < 54; i++) gbuf[i] = 8'((idx * 7 + i * 13) ^ 8'h5A);
    exp_q.push_back({1'b1, 8'h00, 8'h00});
    exp_q.push_back({1'b1, 8'h09, idx});
    for (int i = 0; i < 54; i++) begin
      exp_q.push_back({1'b1, 8'h0A, 8'(i)});
      exp_q.push_back({1'b1, 8'h0B, gbuf[i]});
    end
    exp_q.push_back({1'b1, 8'h08, 8'hA0});
    expect_err = (busy >= limit);
    polls = expect_err ? limit : busy + 1;
    for (int i = 0; i < polls; i++) exp_q.push_back({1'b0, 8'hA0, 8'h00});
    busy_left = busy;
    poll_limit = POLL_W'(limit);
    @(negedge clk);
    char_idx = idx;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    char_idx = ~idx;
    check(lock_own && !cs_n, "R7 lock taken after start", {lock_own, cs_n}, 2);
    check(err == 1'b0, "R9 err cleared by start", err, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    check(done, "R9 done seen", done, 1);
    check(err == expect_err, expect_err ? "R8 timeout err" : "R6 success err", err, expect_err);
    check(cs_n && !lock_own, "R7 released at done", {cs_n, lock_own}, 2);
    check(exp_q.size() == 0, "R4 all transactions issued", exp_q.size(), 0);
    @(negedge clk);
    check(!done, "R9 done one cycle", done, 0);
    repeat (8) @(negedge clk);
    check(!txn_req, "R8 silent after end", txn_req, 0);
    check(err == expect_err, "R9 err retained", err, expect_err);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) gbuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(cs_n && !lock_own && !txn_req && !done && !err, "R1 reset state",
          {cs_n, lock_own, txn_req, done, err}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && !lock_own && !txn_req && !done && !err, "R1 idle after reset",
          {cs_n, lock_own, txn_req, done, err}, 5'b10000);
    bus_lock_busy = 1'b1;
    start = 1'b1;
    char_idx = 8'h33;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check(!lock_own && cs_n && !txn_req, "R2 refused while locked",
          {lock_own, cs_n, txn_req}, 3'b010);
    bus_lock_busy = 1'b0;
    run(8'h41, 3, 10, 1'b1);
    run(8'hFF, 0, 1, 1'b0);
    run(8'h07, 100, 5, 1'b0);
    run(8'h80, 4, 5, 1'b0);
    run(8'h00, 1, 1, 1'b0);
    run(8'h5C, 2, 3, 1'b0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule